// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out the effective address of an operand for a small processor whose instructions occupy two words: an opcode word at the instruction address, followed by an address word that holds a 12-bit address field. The sequencer presents the mode code, the address field, the instruction address, the index register and a general register, then pulses a start strobe. The block answers with a one-cycle completion pulse and the 12-bit effective address. It also raises a flag when the mode code is not defined.

Six modes are handled. Five of them are pure arithmetic on the inputs and finish one cycle after start. The memory-indirect mode needs one extra memory read. The block puts the address field on a request/acknowledge read port, holds the request until memory acknowledges, and takes the returned word as the effective address. All address sums wrap modulo 2^12.

Top module: `eff_addr_unit`

## Requirements
- R1: Mode code 0 (direct) gives an effective address equal to the address field. `done_o` is high in the cycle after the clock edge that samples `start_i`.
- R2: Mode code 3 (indexed) gives the address field plus `index_i`, modulo 2^12. A zero field therefore returns `index_i` unchanged.
- R3: Mode code 2 (relative) gives `instr_addr_i + 2` plus the address field read as a 12-bit two's-complement offset, modulo 2^12. For example, field 0xF05 (-251) at instruction address 749 gives 500.
- R4: Mode code 4 (immediate) gives `instr_addr_i + 1`, which is the location of the address word, modulo 2^12.
- R5: Mode code 5 (register indirect) gives the value of `reg_i`.
- R6: Mode code 1 (memory indirect) raises `mem_req_o` with `mem_addr_o` equal to the address field in the cycle after start. The request holds until `mem_ack_i` is seen high. `done_o` then rises in the next cycle, with `ea_o` equal to the `mem_data_i` word that was present when the acknowledge arrived, and `mem_req_o` low.
- R7: Mode codes 6 and 7 complete like R1 with `illegal_o` high, `ea_o` equal to 0 and no memory request. `illegal_o` is never high without `done_o`.
- R8: While an indirect read is outstanding (`busy_o` high), a start is ignored. It produces no completion and does not change the pending request.
- R9: While reset is asserted, `done_o`, `illegal_o`, `mem_req_o` and `busy_o` are low and `ea_o` is 0.
- R10: `done_o` is high for one cycle per accepted start. `ea_o` keeps its value in every cycle where `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calculation with the current inputs |
| mode_i | input | 3 | Addressing mode code |
| field_i | input | 12 | Address field from the address word |
| instr_addr_i | input | 12 | Address of the instruction's opcode word |
| index_i | input | 12 | Index register value |
| reg_i | input | 12 | Selected general register value |
| mem_ack_i | input | 1 | Memory read acknowledge |
| mem_data_i | input | 12 | Memory read data, valid with acknowledge |
| mem_req_o | output | 1 | Memory read request for indirect mode |
| mem_addr_o | output | 12 | Memory read address |
| busy_o | output | 1 | Indirect read outstanding |
| done_o | output | 1 | Effective address valid (one-cycle pulse) |
| ea_o | output | 12 | Effective address |
| illegal_o | output | 1 | Mode code undefined (with `done_o`) |

## Verification
The arithmetic modes and the undefined codes produce their result exactly one cycle after the edge that samples start. The bench drives start on a falling edge and reads `done_o`, `ea_o` and `illegal_o` at the next falling edge. It reads them again one cycle later to confirm that the pulse has ended and the address has held. In indirect mode the request is due one cycle after start, and completion is due one cycle after the edge that sees the acknowledge. The bench holds off the acknowledge for several cycles, with a stray start in between, and samples each of these outputs at the falling edge that follows the edge where it is due.

// File: rtl/eff_addr_pkg.sv
package eff_addr_pkg;

   typedef enum logic [2:0] {
      AM_DIRECT   = 3'd0,
      AM_MEMIND   = 3'd1,
      AM_RELATIVE = 3'd2,
      AM_INDEXED  = 3'd3,
      AM_IMMED    = 3'd4,
      AM_REGIND   = 3'd5
   } addr_mode_e;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_WAIT = 1'b1
   } seq_state_e;

endpackage

// File: rtl/ea_mode_calc.sv
module ea_mode_calc
   import eff_addr_pkg::*;
#(
   parameter int AW          = 12,
   parameter int FW          = 12,
   parameter bit REL_SIGNED  = 1'b1,
   parameter int INSTR_WORDS = 2
) (
   input  logic [2:0]    mode_i,
   input  logic [FW-1:0] field_i,
   input  logic [AW-1:0] instr_addr_i,
   input  logic [AW-1:0] index_i,
   input  logic [AW-1:0] reg_i,
   output logic [AW-1:0] ea_o,
   output logic          legal_o,
   output logic          needs_mem_o
);

   localparam int            PAD       = AW - FW;
   localparam logic [AW-1:0] STEP_WORD = AW'(1);
   localparam logic [AW-1:0] STEP_NEXT = AW'(INSTR_WORDS);

   logic [AW-1:0] field_ext;
   logic [AW-1:0] rel_off;

   generate
      if (PAD == 0) begin : g_full
         assign field_ext = field_i;
         assign rel_off   = field_i;
      end else begin : g_pad
         assign field_ext = {{PAD{1'b0}}, field_i};
         if (REL_SIGNED) begin : g_sext
            assign rel_off = {{PAD{field_i[FW-1]}}, field_i};
         end else begin : g_zext
            assign rel_off = field_ext;
         end
      end
   endgenerate

   always_comb begin
      ea_o        = '0;
      legal_o     = 1'b1;
      needs_mem_o = 1'b0;
      case (mode_i)
         AM_DIRECT:   ea_o = field_ext;
         AM_MEMIND: begin
            ea_o        = field_ext;
            needs_mem_o = 1'b1;
         end
         AM_RELATIVE: ea_o = instr_addr_i + STEP_NEXT + rel_off;
         AM_INDEXED:  ea_o = field_ext + index_i;
         AM_IMMED:    ea_o = instr_addr_i + STEP_WORD;
         AM_REGIND:   ea_o = reg_i;
         default:     legal_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/ea_mem_seq.sv
module ea_mem_seq
   import eff_addr_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch_i,
   input  logic [AW-1:0] addr_i,
   input  logic          mem_ack_i,
   input  logic [AW-1:0] mem_data_i,
   output logic          mem_req_o,
   output logic [AW-1:0] mem_addr_o,
   output logic          busy_o,
   output logic          fin_o,
   output logic [AW-1:0] fin_data_o
);

   seq_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SQ_IDLE;
         mem_addr_o <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: if (launch_i) begin
               state_q    <= SQ_WAIT;
               mem_addr_o <= addr_i;
            end
            SQ_WAIT: if (mem_ack_i) state_q <= SQ_IDLE;
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign mem_req_o  = (state_q == SQ_WAIT);
   assign busy_o     = mem_req_o;
   assign fin_o      = mem_req_o && mem_ack_i;
   assign fin_data_o = mem_data_i;

   // R6: request and its address hold until acknowledged
   a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

   // R8: a launch is never taken while a read is outstanding
   a_r8_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> $stable(mem_addr_o));

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
   import eff_addr_pkg::*;
#(
   parameter int AW          = 12,
   parameter int FW          = 12,
   parameter bit REL_SIGNED  = 1'b1,
   parameter int INSTR_WORDS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [2:0]    mode_i,
   input  logic [FW-1:0] field_i,
   input  logic [AW-1:0] instr_addr_i,
   input  logic [AW-1:0] index_i,
   input  logic [AW-1:0] reg_i,
   input  logic          mem_ack_i,
   input  logic [AW-1:0] mem_data_i,
   output logic          mem_req_o,
   output logic [AW-1:0] mem_addr_o,
   output logic          busy_o,
   output logic          done_o,
   output logic [AW-1:0] ea_o,
   output logic          illegal_o
);

   initial begin
      assert (FW >= 2 && FW <= AW) else $error("field width must lie in 2..AW");
      assert (INSTR_WORDS >= 2)    else $error("instruction needs at least two words");
   end

   logic [AW-1:0] calc_ea;
   logic          calc_legal;
   logic          calc_mem;
   logic          seq_busy;
   logic          seq_fin;
   logic [AW-1:0] seq_data;
   logic          accept;
   logic          launch;
   logic          quick_fin;

   ea_mode_calc #(
      .AW(AW), .FW(FW), .REL_SIGNED(REL_SIGNED), .INSTR_WORDS(INSTR_WORDS)
   ) u_calc (
      .mode_i       (mode_i),
      .field_i      (field_i),
      .instr_addr_i (instr_addr_i),
      .index_i      (index_i),
      .reg_i        (reg_i),
      .ea_o         (calc_ea),
      .legal_o      (calc_legal),
      .needs_mem_o  (calc_mem)
   );

   assign accept    = start_i && !seq_busy;
   assign launch    = accept && calc_mem;
   assign quick_fin = accept && !calc_mem;

   ea_mem_seq #(.AW(AW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_i   (launch),
      .addr_i     (calc_ea),
      .mem_ack_i  (mem_ack_i),
      .mem_data_i (mem_data_i),
      .mem_req_o  (mem_req_o),
      .mem_addr_o (mem_addr_o),
      .busy_o     (seq_busy),
      .fin_o      (seq_fin),
      .fin_data_o (seq_data)
   );

   assign busy_o = seq_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o    <= 1'b0;
         ea_o      <= '0;
         illegal_o <= 1'b0;
      end else begin
         done_o    <= quick_fin || seq_fin;
         illegal_o <= quick_fin && !calc_legal;
         if (quick_fin)    ea_o <= calc_legal ? calc_ea : '0;
         else if (seq_fin) ea_o <= seq_data;
      end
   end

   // R1: an accepted non-memory start completes on the next cycle
   a_r1_done_next: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && mode_i != AM_MEMIND) |=> done_o);

   // R6: acknowledge leads to completion and a dropped request
   a_r6_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_ack_i) |=> (done_o && !mem_req_o));

   // R7: the illegal flag only appears with completion
   a_r7_illegal_done: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> done_o);

   // R10: the address holds while no completion is shown
   a_r10_ea_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(ea_o));

endmodule

// File: tb/eff_addr_unit_bench.sv
module eff_addr_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NV         = 13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  mode_i = '0;
   logic [11:0] field_i = '0;
   logic [11:0] instr_addr_i = '0;
   logic [11:0] index_i = '0;
   logic [11:0] reg_i = '0;
   logic        mem_ack_i = 1'b0;
   logic [11:0] mem_data_i = '0;
   logic        mem_req_o;
   logic [11:0] mem_addr_o;
   logic        busy_o;
   logic        done_o;
   logic [11:0] ea_o;
   logic        illegal_o;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eff_addr_unit u_eff_addr_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .field_i(field_i), .instr_addr_i(instr_addr_i), .index_i(index_i),
      .reg_i(reg_i), .mem_ack_i(mem_ack_i), .mem_data_i(mem_data_i),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .busy_o(busy_o),
      .done_o(done_o), .ea_o(ea_o), .illegal_o(illegal_o)
   );

   // vectors: mode, field, instr addr, index, reg, expected ea, expected illegal, tag
   localparam logic [2:0]  V_MODE [NV] = '{0, 4, 2, 5, 3, 2, 3, 3, 2, 4, 0, 6, 7};
   localparam logic [11:0] V_FLD  [NV] = '{400, 7, 400, 9, 400, 12'hF05, 12'hFFF, 0, 12'h7FF, 5, 12'hFFF, 33, 44};
   localparam logic [11:0] V_PC   [NV] = '{300, 300, 300, 300, 300, 749, 10, 10, 12'hFFE, 12'hFFF, 0, 50, 60};
   localparam logic [11:0] V_IDX  [NV] = '{11, 11, 11, 11, 200, 0, 2, 200, 3, 3, 3, 8, 8};
   localparam logic [11:0] V_REG  [NV] = '{22, 22, 22, 200, 22, 0, 0, 0, 1, 1, 1, 9, 9};
   localparam logic [11:0] V_EA   [NV] = '{400, 301, 702, 200, 600, 500, 1, 200, 12'h7FF, 0, 12'hFFF, 0, 0};
   localparam bit          V_ILL  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
   localparam string       V_TAG  [NV] = '{"R1", "R4", "R3", "R5", "R2", "R3", "R2", "R2", "R3", "R4", "R1", "R7", "R7"};

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      check("R9 done", done_o, 0);
      check("R9 illegal", illegal_o, 0);
      check("R9 req", mem_req_o, 0);
      check("R9 busy", busy_o, 0);
      check("R9 ea", ea_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         mode_i = V_MODE[i]; field_i = V_FLD[i]; instr_addr_i = V_PC[i];
         index_i = V_IDX[i]; reg_i = V_REG[i]; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         check({V_TAG[i], " done"}, done_o, 1);
         check({V_TAG[i], " ea"}, ea_o, V_EA[i]);
         check({V_TAG[i], " illegal"}, illegal_o, V_ILL[i]);
         check({V_TAG[i], " no req"}, mem_req_o, 0);
         @(negedge clk);
         check("R10 pulse", done_o, 0);
         check("R10 hold", ea_o, V_EA[i]);
      end

      // R6 / R8: memory-indirect read with delayed acknowledge
      mode_i = 3'd1; field_i = 12'd400; mem_data_i = 12'd123; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R6 req", mem_req_o, 1);
      check("R6 addr", mem_addr_o, 400);
      check("R6 busy", busy_o, 1);
      check("R6 no done yet", done_o, 0);
      @(negedge clk);
      mode_i = 3'd0; field_i = 12'd55; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R8 start ignored done", done_o, 0);
      check("R8 start ignored ea", ea_o, 12'hFFF - 12'hFFF);
      check("R8 addr kept", mem_addr_o, 400);
      check("R6 req held", mem_req_o, 1);
      repeat (2) @(negedge clk);
      mem_ack_i = 1'b1;
      @(negedge clk);
      mem_ack_i = 1'b0; mem_data_i = 12'd7;
      check("R6 done", done_o, 1);
      check("R6 ea", ea_o, 123);
      check("R6 req dropped", mem_req_o, 0);
      check("R6 illegal low", illegal_o, 0);
      @(negedge clk);
      check("R10 pulse after ind", done_o, 0);
      check("R10 hold after ind", ea_o, 123);

      // R9: reset in the middle of an indirect read
      mode_i = 3'd1; field_i = 12'd9; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      rst_n = 1'b0;
      #1;
      check("R9 req in reset", mem_req_o, 0);
      check("R9 ea in reset", ea_o, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 busy after reset", busy_o, 0);

      finish_run();
   end

endmodule